// File: doc/BRIEF.md
# Multi-Channel Reloading Down-Counter Timer

This block holds several independent countdown channels behind one small register bus. Each channel has a reload value, a live counter and a control word. A shared run register holds one bit per channel, and software starts or halts a channel by setting or clearing its bit. A running channel decrements its counter once per prescaled tick. When a tick arrives with the counter at zero, the counter reloads from the reload value, a sticky underflow flag is raised, and the channel's interrupt line goes high if the interrupt is enabled.

There are two usual ways to program a channel. For periodic ticks, software writes the period to both the reload value and the counter. For a single delayed event, it writes the delay to the counter and all ones to the reload value, so the next underflow lies as far away as possible. A control write acknowledges the flag. For elapsed-time use, software reads the bitwise complement of the counter, which rises steadily from zero after reset.

Top module: `multi_chan_timer`

## Requirements
- R1: After reset the run register reads 0, every counter and reload value reads 0xFFFFFFFF, every control word reads 0 and every interrupt line is low.
- R2: The run register is at byte address 0x00. Bit k runs channel k, and each bit acts alone without touching other channels. Bits at and above the channel count (3) ignore writes and read as zero.
- R3: Channel k occupies byte address 0x10*(k+1): reload value at +0x0, counter at +0x4, control at +0x8. The control fields are bits 2:0 prescale code, bit 5 interrupt enable and bit 8 underflow flag. All other control bits read as zero, and a write cannot set bit 8.
- R4: Prescale code 000 gives one tick per 4 cycles, 001 per 16, 010 per 64, 011 per 256 and 100 per 1024. Codes 101 to 111 behave as 000. The first tick of a channel falls exactly one period after the clock edge that sets its run bit.
- R5: On each tick of a running channel whose counter is non-zero, the counter decreases by one.
- R6: A tick that finds the counter at zero loads the reload value into the counter and sets the underflow flag.
- R7: A reload value of 0xFFFFFFFF makes the counter wrap to 0xFFFFFFFF after underflow and keep counting down from there (one-shot use). A smaller reload value repeats underflows every reload+1 ticks (periodic use).
- R8: A channel's interrupt line is high exactly when its underflow flag and its interrupt enable are both set.
- R9: A control write with bit 8 equal to 0 clears the underflow flag. A control write with bit 8 equal to 1 leaves the flag as it was.
- R10: A halted channel keeps its counter and its flag unchanged. A counter write loads the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high together with bus_sel |
| bus_addr | input | ADDR_W (8) | Byte address; bits 1:0 must be zero |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| irq | output | NUM_CH (3) | Per-channel underflow interrupt |

## Verification
The bench builds the block with its default parameters: three channels, 32-bit counters and a 10-bit prescaler. With three channels, it can run two channels while a third stays halted, and it can see that run-register bits above bit 2 read back as zero. The full 32-bit width makes the all-ones reload wrap visible. The 10-bit prescaler lets the bench reach the slowest divider, one tick in 1024 cycles, within a short run. Every prescale code, including an out-of-range one, is measured against an exact tick count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PRE_W       = 10;
  localparam int CTRL_W      = 16;
  localparam int CTRL_PS_LSB = 0;
  localparam int CTRL_PS_W   = 3;
  localparam int CTRL_IE_BIT = 5;
  localparam int CTRL_UF_BIT = 8;

  localparam logic [1:0] WORD_RELOAD = 2'd0;
  localparam logic [1:0] WORD_COUNT  = 2'd1;
  localparam logic [1:0] WORD_CTRL   = 2'd2;

  typedef enum logic [CTRL_PS_W-1:0] {
    PS_DIV4    = 3'd0,
    PS_DIV16   = 3'd1,
    PS_DIV64   = 3'd2,
    PS_DIV256  = 3'd3,
    PS_DIV1024 = 3'd4
  } ps_code_e;

  // low prescaler bits that must all be one for a tick
  function automatic logic [PRE_W-1:0] ps_mask(input logic [CTRL_PS_W-1:0] code);
    case (code)
      PS_DIV16:   ps_mask = PRE_W'(15);
      PS_DIV64:   ps_mask = PRE_W'(63);
      PS_DIV256:  ps_mask = PRE_W'(255);
      PS_DIV1024: ps_mask = PRE_W'(1023);
      default:    ps_mask = PRE_W'(3);
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [CTRL_PS_W-1:0] ps_sel,
  output logic                 tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask  = ps_mask(ps_sel);
    // phase restarts whenever the channel is halted
    pre_d = run ? pre_q + PRE_W'(1) : '0;
    tick  = run && ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // every divider is at least 4, so ticks never come back to back
  assert_no_back_to_back_tick_R4: assert property (
    @(posedge clk) disable iff (!rst_n) tick |=> !tick);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              rld_we,
  input  logic              cnt_we,
  input  logic              ctl_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  reload_q,
  output logic [CNT_W-1:0]  count_q,
  output logic [CTRL_W-1:0] ctrl_rd,
  output logic              irq
);
  logic                 tick;
  logic                 at_zero;
  logic [CNT_W-1:0]     reload_d, count_d;
  logic [CTRL_PS_W-1:0] ps_q, ps_d;
  logic                 ie_q, ie_d;
  logic                 uf_q, uf_d;

  tmr_prescaler u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .ps_sel (ps_q),
    .tick   (tick)
  );

  always_comb begin
    at_zero  = (count_q == '0);
    reload_d = rld_we ? wdata[CNT_W-1:0] : reload_q;

    count_d = count_q;
    if (cnt_we)       count_d = wdata[CNT_W-1:0];
    else if (tick)    count_d = at_zero ? reload_q : count_q - CNT_W'(1);

    ps_d = ctl_we ? wdata[CTRL_PS_LSB +: CTRL_PS_W] : ps_q;
    ie_d = ctl_we ? wdata[CTRL_IE_BIT] : ie_q;

    uf_d = uf_q;
    if (tick && at_zero)                       uf_d = 1'b1;
    else if (ctl_we && !wdata[CTRL_UF_BIT])    uf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '1;
      count_q  <= '1;
      ps_q     <= '0;
      ie_q     <= 1'b0;
      uf_q     <= 1'b0;
    end else begin
      reload_q <= reload_d;
      count_q  <= count_d;
      ps_q     <= ps_d;
      ie_q     <= ie_d;
      uf_q     <= uf_d;
    end
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTRL_PS_LSB +: CTRL_PS_W] = ps_q;
    ctrl_rd[CTRL_IE_BIT] = ie_q;
    ctrl_rd[CTRL_UF_BIT] = uf_q;
    irq = uf_q & ie_q;
  end

  assert_decrement_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    tick && !at_zero && !cnt_we |=> count_q == $past(count_q) - CNT_W'(1));

  assert_reload_on_underflow_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    tick && at_zero && !cnt_we |=> count_q == $past(reload_q));

  assert_flag_on_underflow_R6: assert property (
    @(posedge clk) disable iff (!rst_n) tick && at_zero |=> uf_q);

  assert_flag_only_from_tick_R9: assert property (
    @(posedge clk) disable iff (!rst_n) $rose(uf_q) |-> $past(tick));

  assert_hold_when_halted_R10: assert property (
    @(posedge clk) disable iff (!rst_n)
    !run && !cnt_we |=> $stable(count_q));
endmodule

// File: rtl/multi_chan_timer.sv
module multi_chan_timer
  import tmr_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int CNT_W     = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int STRIDE_LG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int BLK_W = ADDR_W - STRIDE_LG;

  logic              wr_en;
  logic              run_hit;
  logic [1:0]        word;
  logic [NUM_CH-1:0] run_q, run_d;
  logic [NUM_CH-1:0] ch_hit;

  logic [CNT_W-1:0]  rld_q [NUM_CH];
  logic [CNT_W-1:0]  cnt_q [NUM_CH];
  logic [CTRL_W-1:0] ctl_q [NUM_CH];

  always_comb begin
    wr_en   = bus_sel & bus_wr;
    run_hit = (bus_addr == '0);
    word    = bus_addr[STRIDE_LG-1:2];
    run_d   = (wr_en && run_hit) ? bus_wdata[NUM_CH-1:0] : run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    assign ch_hit[k] = (bus_addr[ADDR_W-1:STRIDE_LG] == BLK_W'(k + 1)) &&
                       (bus_addr[1:0] == 2'b00);

    tmr_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_q[k]),
      .rld_we   (wr_en && ch_hit[k] && word == WORD_RELOAD),
      .cnt_we   (wr_en && ch_hit[k] && word == WORD_COUNT),
      .ctl_we   (wr_en && ch_hit[k] && word == WORD_CTRL),
      .wdata    (bus_wdata),
      .reload_q (rld_q[k]),
      .count_q  (cnt_q[k]),
      .ctrl_rd  (ctl_q[k]),
      .irq      (irq[k])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (run_hit) bus_rdata[NUM_CH-1:0] = run_q;
    for (int k = 0; k < NUM_CH; k++) begin
      if (ch_hit[k]) begin
        case (word)
          WORD_RELOAD: bus_rdata = DATA_W'(rld_q[k]);
          WORD_COUNT:  bus_rdata = DATA_W'(cnt_q[k]);
          WORD_CTRL:   bus_rdata = DATA_W'(ctl_q[k]);
          default:     bus_rdata = '0;
        endcase
      end
    end
  end

  // a halted channel never raises a fresh interrupt
  for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
    assert_no_irq_rise_when_halted_R10: assert property (
      @(posedge clk) disable iff (!rst_n)
      !run_q[k] |=> !$rose(irq[k]) || $past(wr_en));
  end
endmodule

// File: tb/test_multi_chan_timer.sv
`timescale 1ns/100ps
module test_multi_chan_timer;
  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int n_chk;
  int n_bad;
  bit done;

  multi_chan_timer i_multi_chan_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [1:0]  ch;
    logic [2:0]  code;
    logic        ie;
    logic [31:0] rld;
    logic [31:0] cnt;
    logic [15:0] wt;
    logic [31:0] exp_cnt;
    logic        exp_uf;
  } vec_t;

  // stimulus and expected count/flag after wt cycles of running
  localparam vec_t VECS [8] = '{
    '{2'd0, 3'd0, 1'b1, 32'd5,          32'd3, 16'd12,   32'd0,          1'b0},
    '{2'd0, 3'd0, 1'b1, 32'd5,          32'd3, 16'd16,   32'd5,          1'b1},
    '{2'd1, 3'd1, 1'b0, 32'd2,          32'd1, 16'd80,   32'd2,          1'b1},
    '{2'd2, 3'd2, 1'b1, 32'd100,        32'd10, 16'd128, 32'd8,          1'b0},
    '{2'd1, 3'd3, 1'b1, 32'd0,          32'd0, 16'd512,  32'd0,          1'b1},
    '{2'd2, 3'd4, 1'b1, 32'd7,          32'd0, 16'd1024, 32'd7,          1'b1},
    '{2'd0, 3'd7, 1'b0, 32'd1,          32'd2, 16'd20,   32'd1,          1'b1},
    '{2'd1, 3'd0, 1'b1, 32'hFFFF_FFFF,  32'd1, 16'd12,   32'hFFFF_FFFE,  1'b1}
  };

  function automatic logic [7:0] ch_addr(input int ch, input int wd);
    return 8'(16 * (ch + 1) + 4 * wd);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.2;
    d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    n_chk = 0; n_bad = 0; done = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(8'h00, rd);             check("R1 run reg", rd, 32'h0);
    for (int c = 0; c < 3; c++) begin
      bus_read(ch_addr(c, 0), rd);   check("R1 reload", rd, 32'hFFFF_FFFF);
      bus_read(ch_addr(c, 1), rd);   check("R1 counter", rd, 32'hFFFF_FFFF);
      bus_read(ch_addr(c, 2), rd);   check("R1 control", rd, 32'h0);
    end
    check("R1 irq", 32'(irq), 32'h0);

    // R3 control fields: only 2:0, 5, 8 exist; bit 8 cannot be set by a write
    bus_write(ch_addr(2, 2), 32'h0000_FFFF);
    bus_read(ch_addr(2, 2), rd);     check("R3 control readback", rd, 32'h0000_0027);

    // R2 unused run bits read zero
    bus_write(8'h00, 32'h0000_00FF);
    bus_read(8'h00, rd);             check("R2 run reg width", rd, 32'h0000_0007);
    bus_write(8'h00, 32'h0);

    // table walk: R4 R5 R6 R7 R8 R10 (counter load while halted)
    for (int i = 0; i < 8; i++) begin
      bus_write(8'h00, 32'h0);
      bus_write(ch_addr(VECS[i].ch, 2), 32'(VECS[i].code) | (32'(VECS[i].ie) << 5));
      bus_write(ch_addr(VECS[i].ch, 0), VECS[i].rld);
      bus_write(ch_addr(VECS[i].ch, 1), VECS[i].cnt);
      bus_write(8'h00, 32'h1 << VECS[i].ch);
      repeat (int'(VECS[i].wt)) @(negedge clk);
      bus_read(ch_addr(VECS[i].ch, 1), rd);
      check("R4 R5 R6 R7 counter after ticks", rd, VECS[i].exp_cnt);
      bus_read(ch_addr(VECS[i].ch, 2), rd);
      check("R6 control with flag", rd,
            32'(VECS[i].code) | (32'(VECS[i].ie) << 5) | (32'(VECS[i].exp_uf) << 8));
      check("R8 irq line", 32'(irq[VECS[i].ch]), 32'(VECS[i].exp_uf & VECS[i].ie));
    end
    bus_write(8'h00, 32'h0);

    // R2 independence: run ch0 and ch2, ch1 stays halted
    for (int c = 0; c < 3; c++) begin
      bus_write(ch_addr(c, 2), 32'h0);
      bus_write(ch_addr(c, 1), 32'd100);
    end
    bus_write(8'h00, 32'h0000_0005);
    repeat (40) @(negedge clk);
    bus_read(ch_addr(0, 1), rd);     check("R2 ch0 running", rd, 32'd90);
    bus_read(ch_addr(1, 1), rd);     check("R2 ch1 halted", rd, 32'd100);
    bus_read(ch_addr(2, 1), rd);     check("R2 ch2 running", rd, 32'd90);
    bus_write(8'h00, 32'h0);

    // R10 halted channel keeps count and flag
    bus_write(ch_addr(0, 2), 32'h0000_0020);
    bus_write(ch_addr(0, 0), 32'd9);
    bus_write(ch_addr(0, 1), 32'd0);
    bus_write(8'h00, 32'h1);
    repeat (4) @(negedge clk);
    bus_read(ch_addr(0, 1), rd);     check("R6 first tick underflows", rd, 32'd9);
    check("R8 irq raised", 32'(irq[0]), 32'h1);
    bus_write(8'h00, 32'h0);
    repeat (50) @(negedge clk);
    bus_read(ch_addr(0, 1), rd);     check("R10 count held", rd, 32'd9);
    bus_read(ch_addr(0, 2), rd);     check("R10 flag held", rd, 32'h0000_0120);

    // R9 acknowledge behaviour
    bus_write(ch_addr(0, 2), 32'h0000_0120);
    bus_read(ch_addr(0, 2), rd);     check("R9 bit8=1 keeps flag", rd, 32'h0000_0120);
    check("R9 irq kept", 32'(irq[0]), 32'h1);
    bus_write(ch_addr(0, 2), 32'h0000_0020);
    bus_read(ch_addr(0, 2), rd);     check("R9 bit8=0 clears flag", rd, 32'h0000_0020);
    check("R9 irq cleared", 32'(irq[0]), 32'h0);

    // R8 flag without enable keeps irq low
    bus_write(ch_addr(0, 2), 32'h0000_0000);
    bus_write(ch_addr(0, 1), 32'd0);
    bus_write(8'h00, 32'h1);
    repeat (4) @(negedge clk);
    bus_read(ch_addr(0, 2), rd);     check("R8 flag set, enable off", rd, 32'h0000_0100);
    check("R8 irq masked", 32'(irq[0]), 32'h0);
    bus_write(8'h00, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule